// File: doc/BRIEF.md
# Implicit GEMM Convolution Activation Address Generator

This block produces the activation-tensor read addresses for a 2-D forward convolution that is computed as a matrix product. It never builds the expanded convolution matrix. Each GEMM row is one output pixel (n, p, q). The reduction index visits filter positions (r, s) and channel tiles. For each access the block emits the NHWC element address of the first channel of a channel tile, plus an in-bounds flag. The flag is low where the access falls into the padding region. A downstream loader fetches `CH_TILE` consecutive channels at that address, and substitutes zeros when the flag is low.

Rows are handled in blocks of `ROWS` rows. The states are:
- **ST_IDLE:** waits for `start`. On `start` it moves to ST_SETUP.
- **ST_SETUP:** loads one row lane per cycle from a row cursor. The cursor steps through q, then p, then n incrementally, so no division is needed. After `ROWS` cycles the block moves to ST_ISSUE.
- **ST_ISSUE:** emits one access per accepted handshake. Every live lane is emitted for the current tile. The lanes then all advance together by one entry of a three-entry increment table: next-s, next-r or next-c. After the last tile of the block it goes back to ST_SETUP if rows remain, otherwise to ST_DONE.
- **ST_DONE:** raises `done` for one cycle, then returns to ST_IDLE.

The configuration inputs must stay stable from `start` until `done`. `cfg_slices` must be at least 1, `cfg_c` must be a multiple of `CH_TILE`, and N, P, Q, R, S must all be at least 1.

Top module: `conv_addr_gen`

## Requirements
- R1: After reset, `busy`, `done` and `out_valid` are 0. `out_valid` is never 1 while `busy` is 0.
- R2: A `start` pulse in ST_IDLE makes `busy` 1 from the next cycle. A `start` pulse while busy or in ST_DONE is ignored, and the access sequence is unchanged.
- R3: Access order, from outermost to innermost:
  - row block b, covering rows i = b*ROWS .. b*ROWS+ROWS-1;
  - channel tile;
  - filter row counter r = 0..R-1;
  - filter column counter s = 0..S-1;
  - rows of the block in ascending i.
  Row i decomposes as n = i/(P*Q), p = (i mod P*Q)/Q, q = (i mod P*Q) mod Q.
- R4: With `cfg_conv`=0 (cross-correlation), the input coordinates are h = p*stride_h - pad_h + r*dil_h and w = q*stride_w - pad_w + s*dil_w. The address is ((n*H + h)*W + w)*C + c, as a signed value, even when out of bounds.
- R5: With `cfg_conv`=1 (true convolution), R-1-r replaces r and S-1-s replaces s in the R4 formulas.
- R6: `out_inb` is 1 exactly when 0 <= h < H and 0 <= w < W.
- R7: The first channel tile starts at c = cfg_slice_idx*CH_TILE. Each later tile adds CH_TILE*cfg_slices. Tiles stop once c >= C.
- R8: `out_valid`=1 and `out_ready`=0 holds `out_valid`, `out_addr` and `out_inb` unchanged in the next cycle. With `out_ready` held at 1, one access is accepted per cycle within a row block.
- R9: `done` is 1 for exactly one cycle, in the cycle after the last access is accepted, with `busy` and `out_valid` at 0.
- R10: A final row block with fewer than ROWS rows, where i >= N*P*Q for some lanes, emits only the rows below N*P*Q.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (accepted in ST_IDLE) |
| cfg_n | input | DIM_W | Batch count N |
| cfg_h | input | DIM_W | Input height H |
| cfg_w | input | DIM_W | Input width W |
| cfg_c | input | DIM_W | Channel count C |
| cfg_r | input | DIM_W | Filter height R |
| cfg_s | input | DIM_W | Filter width S |
| cfg_p | input | DIM_W | Output height P |
| cfg_q | input | DIM_W | Output width Q |
| cfg_stride_h | input | STEP_W | Vertical stride |
| cfg_stride_w | input | STEP_W | Horizontal stride |
| cfg_pad_h | input | STEP_W | Vertical padding |
| cfg_pad_w | input | STEP_W | Horizontal padding |
| cfg_dil_h | input | STEP_W | Vertical dilation |
| cfg_dil_w | input | STEP_W | Horizontal dilation |
| cfg_conv | input | 1 | 1 = true convolution (flipped filter), 0 = cross-correlation |
| cfg_slices | input | SLICE_W | Number of reduction slices (>= 1) |
| cfg_slice_idx | input | SLICE_W | This generator's slice index |
| out_ready | input | 1 | Consumer accepts the current access |
| busy | output | 1 | In ST_SETUP or ST_ISSUE |
| done | output | 1 | One-cycle completion pulse (ST_DONE) |
| out_valid | output | 1 | An access is presented |
| out_addr | output | ADDR_W | Signed NHWC element address |
| out_inb | output | 1 | Access lies inside the tensor |

## Verification
The bench builds the block with ROWS=3 and CH_TILE=4. Three lanes do not divide the 16, 8 and 4 output-pixel problems it runs, so short final row blocks appear (R10). A 3-by-3 padded cross-correlation walks through all three increment moves under pseudo-random back-pressure. A strided, dilated convolution with two slices and slice index 1 checks the filter flip and the offset channel start. A 1-by-1 filter uses only the next-c move. A 2-by-2 convolution spanning three channel tiles checks repeated channel advances.

// File: rtl/conv_ag_pkg.sv
package conv_ag_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_ISSUE = 2'd2,
        ST_DONE  = 2'd3
    } ag_state_e;

    typedef enum logic [1:0] {
        MOVE_S = 2'd0,
        MOVE_R = 2'd1,
        MOVE_C = 2'd2
    } move_e;
endpackage

// File: rtl/conv_ag_inc_table.sv
module conv_ag_inc_table #(
    parameter int AW = 32
) (
    input  logic signed [AW-1:0] w_s,
    input  logic signed [AW-1:0] c_s,
    input  logic signed [AW-1:0] r_s,
    input  logic signed [AW-1:0] s_s,
    input  logic signed [AW-1:0] dh_s,
    input  logic signed [AW-1:0] dw_s,
    input  logic signed [AW-1:0] chan_step,
    input  logic                 conv,
    output logic signed [AW-1:0] inc_a [3],
    output logic signed [AW-1:0] inc_h [3],
    output logic signed [AW-1:0] inc_w [3]
);
    logic signed [AW-1:0] sdh, sdw, pitch, col_back, row_back;

    always_comb begin
        // flipped filters walk the input backwards
        sdh      = conv ? -dh_s : dh_s;
        sdw      = conv ? -dw_s : dw_s;
        pitch    = w_s * c_s;
        col_back = (s_s - 1) * sdw;
        row_back = (r_s - 1) * sdh;
        inc_h[0] = '0;
        inc_w[0] = sdw;
        inc_a[0] = sdw * c_s;
        inc_h[1] = sdh;
        inc_w[1] = -col_back;
        inc_a[1] = sdh * pitch - col_back * c_s;
        inc_h[2] = -row_back;
        inc_w[2] = -col_back;
        inc_a[2] = chan_step - row_back * pitch - col_back * c_s;
    end
endmodule

// File: rtl/conv_ag_cursor.sv
module conv_ag_cursor #(
    parameter int AW     = 32,
    parameter int DIM_W  = 8,
    parameter int STEP_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 restart,
    input  logic                 step,
    input  logic [DIM_W-1:0]     cfg_h,
    input  logic [DIM_W-1:0]     cfg_w,
    input  logic [DIM_W-1:0]     cfg_c,
    input  logic [DIM_W-1:0]     cfg_r,
    input  logic [DIM_W-1:0]     cfg_s,
    input  logic [DIM_W-1:0]     cfg_p,
    input  logic [DIM_W-1:0]     cfg_q,
    input  logic [STEP_W-1:0]    cfg_stride_h,
    input  logic [STEP_W-1:0]    cfg_stride_w,
    input  logic [STEP_W-1:0]    cfg_pad_h,
    input  logic [STEP_W-1:0]    cfg_pad_w,
    input  logic [STEP_W-1:0]    cfg_dil_h,
    input  logic [STEP_W-1:0]    cfg_dil_w,
    input  logic                 cfg_conv,
    input  logic signed [AW-1:0] c0,
    output logic signed [AW-1:0] ld_h,
    output logic signed [AW-1:0] ld_w,
    output logic signed [AW-1:0] ld_a
);
    logic [DIM_W-1:0] n_cnt, p_cnt, q_cnt;
    logic signed [AW-1:0] ns, ps, qs, hs, ws, cs, rs, ss;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            n_cnt <= '0; p_cnt <= '0; q_cnt <= '0;
        end else if (restart) begin
            n_cnt <= '0; p_cnt <= '0; q_cnt <= '0;
        end else if (step) begin
            if (q_cnt == cfg_q - 1'b1) begin
                q_cnt <= '0;
                if (p_cnt == cfg_p - 1'b1) begin
                    p_cnt <= '0;
                    n_cnt <= n_cnt + 1'b1;
                end else begin
                    p_cnt <= p_cnt + 1'b1;
                end
            end else begin
                q_cnt <= q_cnt + 1'b1;
            end
        end
    end

    always_comb begin
        ns = AW'(n_cnt); ps = AW'(p_cnt); qs = AW'(q_cnt);
        hs = AW'(cfg_h); ws = AW'(cfg_w); cs = AW'(cfg_c);
        rs = AW'(cfg_r); ss = AW'(cfg_s);
        ld_h = ps * AW'(cfg_stride_h) - AW'(cfg_pad_h)
             + (cfg_conv ? (rs - 1) * AW'(cfg_dil_h) : '0);
        ld_w = qs * AW'(cfg_stride_w) - AW'(cfg_pad_w)
             + (cfg_conv ? (ss - 1) * AW'(cfg_dil_w) : '0);
        ld_a = ((ns * hs + ld_h) * ws + ld_w) * cs + c0;
    end
endmodule

// File: rtl/conv_ag_lane.sv
module conv_ag_lane #(
    parameter int AW = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic                 adv,
    input  logic signed [AW-1:0] ld_h,
    input  logic signed [AW-1:0] ld_w,
    input  logic signed [AW-1:0] ld_a,
    input  logic signed [AW-1:0] inc_h,
    input  logic signed [AW-1:0] inc_w,
    input  logic signed [AW-1:0] inc_a,
    output logic signed [AW-1:0] h,
    output logic signed [AW-1:0] w,
    output logic signed [AW-1:0] a
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h <= '0; w <= '0; a <= '0;
        end else if (load) begin
            h <= ld_h; w <= ld_w; a <= ld_a;
        end else if (adv) begin
            h <= h + inc_h; w <= w + inc_w; a <= a + inc_a;
        end
    end
endmodule

// File: rtl/conv_addr_gen.sv
module conv_addr_gen
    import conv_ag_pkg::*;
#(
    parameter int DIM_W   = 8,
    parameter int STEP_W  = 4,
    parameter int SLICE_W = 3,
    parameter int ADDR_W  = 32,
    parameter int CH_TILE = 4,
    parameter int ROWS    = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [DIM_W-1:0]         cfg_n,
    input  logic [DIM_W-1:0]         cfg_h,
    input  logic [DIM_W-1:0]         cfg_w,
    input  logic [DIM_W-1:0]         cfg_c,
    input  logic [DIM_W-1:0]         cfg_r,
    input  logic [DIM_W-1:0]         cfg_s,
    input  logic [DIM_W-1:0]         cfg_p,
    input  logic [DIM_W-1:0]         cfg_q,
    input  logic [STEP_W-1:0]        cfg_stride_h,
    input  logic [STEP_W-1:0]        cfg_stride_w,
    input  logic [STEP_W-1:0]        cfg_pad_h,
    input  logic [STEP_W-1:0]        cfg_pad_w,
    input  logic [STEP_W-1:0]        cfg_dil_h,
    input  logic [STEP_W-1:0]        cfg_dil_w,
    input  logic                     cfg_conv,
    input  logic [SLICE_W-1:0]       cfg_slices,
    input  logic [SLICE_W-1:0]       cfg_slice_idx,
    input  logic                     out_ready,
    output logic                     busy,
    output logic                     done,
    output logic                     out_valid,
    output logic signed [ADDR_W-1:0] out_addr,
    output logic                     out_inb
);
    localparam int LW = (ROWS > 1) ? $clog2(ROWS) : 1;
    localparam int MW = 3 * DIM_W;

    ag_state_e state, state_nx;
    move_e     move;

    logic [LW-1:0]    setup_idx, li, last_li;
    logic [DIM_W-1:0] s_it, r_it;
    logic [MW-1:0]    row_cnt, m_total;
    logic signed [ADDR_W-1:0] c_cur, c0, chan_step, c_lim, h_lim, w_lim;
    logic signed [ADDR_W-1:0] ld_h, ld_w, ld_a;
    logic signed [ADDR_W-1:0] inc_a [3];
    logic signed [ADDR_W-1:0] inc_h [3];
    logic signed [ADDR_W-1:0] inc_w [3];
    logic signed [ADDR_W-1:0] lane_h [ROWS];
    logic signed [ADDR_W-1:0] lane_w [ROWS];
    logic signed [ADDR_W-1:0] lane_a [ROWS];
    logic tile_end, last_tile, lane_adv, setup_last, rows_left;

    assign c0        = ADDR_W'(cfg_slice_idx) * ADDR_W'(CH_TILE);
    assign chan_step = ADDR_W'(cfg_slices) * ADDR_W'(CH_TILE);
    assign c_lim     = ADDR_W'(cfg_c);
    assign h_lim     = ADDR_W'(cfg_h);
    assign w_lim     = ADDR_W'(cfg_w);
    assign m_total   = MW'(cfg_n) * MW'(cfg_p) * MW'(cfg_q);
    assign rows_left = row_cnt < m_total;

    conv_ag_inc_table #(.AW(ADDR_W)) u_table (
        .w_s(w_lim), .c_s(c_lim), .r_s(ADDR_W'(cfg_r)), .s_s(ADDR_W'(cfg_s)),
        .dh_s(ADDR_W'(cfg_dil_h)), .dw_s(ADDR_W'(cfg_dil_w)),
        .chan_step(chan_step), .conv(cfg_conv),
        .inc_a(inc_a), .inc_h(inc_h), .inc_w(inc_w)
    );

    conv_ag_cursor #(.AW(ADDR_W), .DIM_W(DIM_W), .STEP_W(STEP_W)) u_cursor (
        .clk(clk), .rst_n(rst_n),
        .restart(state == ST_IDLE && start), .step(state == ST_SETUP),
        .cfg_h(cfg_h), .cfg_w(cfg_w), .cfg_c(cfg_c), .cfg_r(cfg_r), .cfg_s(cfg_s),
        .cfg_p(cfg_p), .cfg_q(cfg_q),
        .cfg_stride_h(cfg_stride_h), .cfg_stride_w(cfg_stride_w),
        .cfg_pad_h(cfg_pad_h), .cfg_pad_w(cfg_pad_w),
        .cfg_dil_h(cfg_dil_h), .cfg_dil_w(cfg_dil_w),
        .cfg_conv(cfg_conv), .c0(c0),
        .ld_h(ld_h), .ld_w(ld_w), .ld_a(ld_a)
    );

    // Filter move chosen from the s/r iteration counters
    always_comb begin
        if (s_it != cfg_s - 1'b1)      move = MOVE_S;
        else if (r_it != cfg_r - 1'b1) move = MOVE_R;
        else                           move = MOVE_C;
    end

    assign tile_end   = (state == ST_ISSUE) && out_ready && (li == last_li);
    assign last_tile  = (move == MOVE_C) && (c_cur + chan_step >= c_lim);
    assign lane_adv   = tile_end;
    assign setup_last = (setup_idx == LW'(ROWS - 1));

    genvar gl;
    generate
        for (gl = 0; gl < ROWS; gl++) begin : g_lane
            conv_ag_lane #(.AW(ADDR_W)) u_lane (
                .clk(clk), .rst_n(rst_n),
                .load(state == ST_SETUP && setup_idx == LW'(gl)),
                .adv(lane_adv),
                .ld_h(ld_h), .ld_w(ld_w), .ld_a(ld_a),
                .inc_h(inc_h[move]), .inc_w(inc_w[move]), .inc_a(inc_a[move]),
                .h(lane_h[gl]), .w(lane_w[gl]), .a(lane_a[gl])
            );
        end
    endgenerate

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start) state_nx = ST_SETUP;
            ST_SETUP: if (setup_last) state_nx = ST_ISSUE;
            ST_ISSUE: if (tile_end && last_tile) state_nx = rows_left ? ST_SETUP : ST_DONE;
            ST_DONE:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Iteration counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            setup_idx <= '0; li <= '0; last_li <= '0;
            s_it <= '0; r_it <= '0; c_cur <= '0; row_cnt <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        setup_idx <= '0;
                        row_cnt   <= '0;
                    end
                end
                ST_SETUP: begin
                    setup_idx <= setup_last ? '0 : setup_idx + 1'b1;
                    row_cnt   <= row_cnt + 1'b1;
                    if (rows_left) last_li <= setup_idx;
                    s_it  <= '0;
                    r_it  <= '0;
                    c_cur <= c0;
                    li    <= '0;
                end
                ST_ISSUE: begin
                    if (out_ready) begin
                        if (li != last_li) begin
                            li <= li + 1'b1;
                        end else begin
                            li <= '0;
                            unique case (move)
                                MOVE_S: s_it <= s_it + 1'b1;
                                MOVE_R: begin
                                    s_it <= '0;
                                    r_it <= r_it + 1'b1;
                                end
                                default: begin
                                    s_it  <= '0;
                                    r_it  <= '0;
                                    c_cur <= c_cur + chan_step;
                                end
                            endcase
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy      = (state == ST_SETUP) || (state == ST_ISSUE);
        done      = (state == ST_DONE);
        out_valid = (state == ST_ISSUE);
        out_addr  = lane_a[li];
        out_inb   = (lane_h[li] >= 0) && (lane_h[li] < h_lim) &&
                    (lane_w[li] >= 0) && (lane_w[li] < w_lim);
    end
endmodule

// File: rtl/conv_ag_checker.sv
module conv_ag_checker #(
    parameter int AW = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 start,
    input logic                 busy,
    input logic                 done,
    input logic                 out_valid,
    input logic                 out_ready,
    input logic signed [AW-1:0] out_addr,
    input logic                 out_inb
);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !out_valid);

    assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !done) |=> busy);

    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_inb)));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !out_valid));

    assert_done_after_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));
endmodule

bind conv_addr_gen conv_ag_checker #(.AW(ADDR_W)) u_checker (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr), .out_inb(out_inb)
);

// File: tb/conv_addr_gen_tb.sv
module conv_addr_gen_tb;
    localparam int DIM_W = 8, STEP_W = 4, SLICE_W = 3, ADDR_W = 32;
    localparam int CH_TILE = 4, ROWS = 3;

    logic clk = 0, rst_n = 0, start = 0, out_ready = 1;
    logic [DIM_W-1:0]   cfg_n, cfg_h, cfg_w, cfg_c, cfg_r, cfg_s, cfg_p, cfg_q;
    logic [STEP_W-1:0]  cfg_stride_h, cfg_stride_w, cfg_pad_h, cfg_pad_w, cfg_dil_h, cfg_dil_w;
    logic               cfg_conv;
    logic [SLICE_W-1:0] cfg_slices, cfg_slice_idx;
    logic busy, done, out_valid, out_inb;
    logic signed [ADDR_W-1:0] out_addr;

    int checks = 0, fails = 0, cyc = 0;
    int exp_a[$];
    bit exp_v[$];
    bit bp_en = 0;
    logic [7:0] lfsr = 8'h5a;
    string tag = "";

    always #5 clk = ~clk;

    conv_addr_gen #(.DIM_W(DIM_W), .STEP_W(STEP_W), .SLICE_W(SLICE_W), .ADDR_W(ADDR_W),
                    .CH_TILE(CH_TILE), .ROWS(ROWS)) u_dut (.*);

    task automatic report_summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++; fails++;
            $display("FAIL watchdog: run hung, got cycle %0d expected below 150000", cyc);
            report_summary();
            $finish;
        end
    end

    // Monitor: pops and compares every accepted access (R3 R4 R5 R6 R7 R8 R10)
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            checks++;
            if (exp_a.size() == 0) begin
                fails++;
                $display("FAIL R3 %s: unexpected access got addr=%0d expected none", tag, out_addr);
            end else begin
                int ea; bit ev;
                ea = exp_a.pop_front();
                ev = exp_v.pop_front();
                if (out_addr !== ea || out_inb !== ev) begin
                    fails++;
                    $display("FAIL R3 R6 R8 %s: got addr=%0d inb=%0b expected addr=%0d inb=%0b",
                             tag, out_addr, out_inb, ea, ev);
                end
            end
        end
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        out_ready = bp_en ? (lfsr[0] | lfsr[2]) : 1'b1;
    end

    task automatic check(input string req, input logic got, input logic expv);
        checks++;
        if (got !== expv) begin
            fails++;
            $display("FAIL %s: got %0b expected %0b", req, got, expv);
        end
    endtask

    // Driver: loads config, pushes the expected stream, runs the block
    task automatic run_cfg(input int n, h, w, c, r, s, p, q, sh, sw, ph, pw, dh, dw,
                           input bit conv, input int slices, sidx, input bit bp,
                           input bit restart_mid, input string t);
        int m, c0, step;
        cfg_n = n; cfg_h = h; cfg_w = w; cfg_c = c; cfg_r = r; cfg_s = s;
        cfg_p = p; cfg_q = q; cfg_stride_h = sh; cfg_stride_w = sw;
        cfg_pad_h = ph; cfg_pad_w = pw; cfg_dil_h = dh; cfg_dil_w = dw;
        cfg_conv = conv; cfg_slices = slices; cfg_slice_idx = sidx;
        tag = t; bp_en = bp;
        m = n * p * q; c0 = sidx * CH_TILE; step = slices * CH_TILE;
        for (int b = 0; b * ROWS < m; b++)
            for (int cc = c0; cc < c; cc += step)
                for (int ri = 0; ri < r; ri++)
                    for (int si = 0; si < s; si++)
                        for (int l = 0; l < ROWS; l++) begin
                            int i, nn, pp, qq, rf, sf, hh, ww;
                            i = b * ROWS + l;
                            if (i < m) begin
                                nn = i / (p * q);
                                pp = (i % (p * q)) / q;
                                qq = (i % (p * q)) % q;
                                rf = conv ? r - 1 - ri : ri;
                                sf = conv ? s - 1 - si : si;
                                hh = pp * sh - ph + rf * dh;
                                ww = qq * sw - pw + sf * dw;
                                exp_a.push_back(((nn * h + hh) * w + ww) * c + cc);
                                exp_v.push_back(hh >= 0 && hh < h && ww >= 0 && ww < w);
                            end
                        end
        @(posedge clk); #2;
        start = 1;
        @(posedge clk); #2;
        start = 0;
        check({"R2 busy after start ", t}, busy, 1'b1);
        if (restart_mid) begin
            repeat (20) @(posedge clk);
            #2 start = 1;
            @(posedge clk); #2 start = 0;
        end
        while (done !== 1'b1) begin
            @(posedge clk); #2;
        end
        checks++;
        if (exp_a.size() != 0) begin
            fails++;
            $display("FAIL R9 %s: done with %0d accesses missing, expected 0", t, exp_a.size());
        end
        @(posedge clk); #2;
        check({"R9 done one cycle ", t}, done, 1'b0);
        check({"R9 idle after done ", t}, busy, 1'b0);
        exp_a.delete(); exp_v.delete();
    endtask

    initial begin
        cfg_n = 1; cfg_h = 1; cfg_w = 1; cfg_c = 4; cfg_r = 1; cfg_s = 1; cfg_p = 1; cfg_q = 1;
        cfg_stride_h = 1; cfg_stride_w = 1; cfg_pad_h = 0; cfg_pad_w = 0;
        cfg_dil_h = 1; cfg_dil_w = 1; cfg_conv = 0; cfg_slices = 1; cfg_slice_idx = 0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        @(posedge clk); #2;
        check("R1 busy after reset", busy, 1'b0);
        check("R1 done after reset", done, 1'b0);
        check("R1 out_valid after reset", out_valid, 1'b0);
        // R4 R6 R10: padded 3x3 cross-correlation, back-pressure, mid-run start ignored (R2)
        run_cfg(1, 4, 4, 8, 3, 3, 4, 4, 1, 1, 1, 1, 1, 1, 0, 1, 0, 1, 1, "R4 R10 xcorr3x3");
        // R5 R7: strided dilated convolution, two slices, slice index 1
        run_cfg(2, 5, 6, 8, 2, 3, 2, 2, 2, 2, 2, 1, 2, 2, 1, 2, 1, 0, 0, "R5 R7 conv_slice");
        // R4 R7: 1x1 filter, only channel moves, exact row blocks
        run_cfg(1, 3, 3, 4, 1, 1, 3, 3, 1, 1, 0, 0, 1, 1, 0, 1, 0, 0, 0, "R4 R7 pointwise");
        // R5 R7 R10: 2x2 convolution over three channel tiles, back-pressure
        run_cfg(1, 3, 3, 12, 2, 2, 2, 2, 1, 1, 0, 0, 1, 1, 1, 1, 0, 1, 0, "R5 R7 R10 conv3tile");
        report_summary();
        $finish;
    end
endmodule